// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block registers the address and command bus between a memory controller and a bank of DRAM devices. On every rising clock edge it samples a group of gated data bits plus the chip-select, clock-enable and termination strobes, and drives each sampled bit onto two identical output copies, A and B. Each copy feeds its own half of the module load.

Power is saved by not toggling the gated data outputs while the memory is not addressed. When the gate enable input is high and chip select (active low) is deasserted at an edge, the gated outputs keep their last values. When gate enable is low, the gated data is re-registered on every edge. The chip-select, clock-enable and termination bits are never gated. An active-low asynchronous reset clears every flop.

A small controller decides, edge by edge, whether the gated bank loads. It has three states:
- `GS_IDLE`: entered on reset, before any edge.
- `GS_LOAD`: entered on any edge where chip select is low or gate enable is low.
- `GS_HOLD`: entered on any edge where both chip select and gate enable are high.

Any state goes to `GS_LOAD` or `GS_HOLD` by that same rule at every edge. Any state goes to `GS_IDLE` when reset is asserted.

Top module: `cs_gated_cmd_reg`

## Requirements
- R1: While `rst_n` is low, every output is 0, and this takes effect without waiting for a clock edge.
- R2: At a rising edge with `sel_n` = 1 and `gate_en` = 1, `data_a`/`data_b` keep their previous value.
- R3: At a rising edge with `sel_n` = 0, `data_a`/`data_b` take the value of `data_in`.
- R4: At a rising edge with `gate_en` = 0, `data_a`/`data_b` take `data_in` whatever the level of `sel_n`.
- R5: `cke_a`/`cke_b` and `odt_a`/`odt_b` take `cke_in` and `odt_in` at every rising edge, whatever the levels of `sel_n` and `gate_en`.
- R6: `sel_n_a`/`sel_n_b` take `sel_n` at every rising edge.
- R7: Each A output always equals its B counterpart.
- R8: Outputs change only at rising clock edges. An input change between edges leaves every output unchanged until the next edge.
- R9: After `rst_n` rises, all outputs stay 0 through edges that capture only zeros. They change only at the first edge that captures a 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | 1: gated bits load only while chip select is low; 0: they load every edge |
| sel_n | input | 1 | Chip select, active low |
| data_in | input | 11 | Gated address/command bits |
| cke_in | input | 1 | Clock-enable strobe, ungated |
| odt_in | input | 1 | Termination strobe, ungated |
| data_a | output | 11 | Registered gated bits, copy A |
| data_b | output | 11 | Registered gated bits, copy B |
| sel_n_a | output | 1 | Registered chip select, copy A |
| sel_n_b | output | 1 | Registered chip select, copy B |
| cke_a | output | 1 | Registered clock enable, copy A |
| cke_b | output | 1 | Registered clock enable, copy B |
| odt_a | output | 1 | Registered termination, copy A |
| odt_b | output | 1 | Registered termination, copy B |

## Verification
Every registered result is due exactly one rising edge after its inputs are applied. The only exception is reset, which clears the outputs at once with no edge. The bench drives inputs one time unit after an edge and samples one time unit after the following edge. It compares the outputs against a reference that applies the load rule to the values it drove. The bench checks reset clearing within a single time unit and mid-cycle. It also changes inputs between edges and confirms the outputs hold until the next edge.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    // Default width of the gated address/command bank.
    parameter int GATED_W = 11;

    // Number of ungated strobes: chip select, clock enable, termination.
    parameter int STROBE_W = 3;

    // Decision taken by the gate controller at the most recent edge.
    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_LOAD = 2'd1,
        GS_HOLD = 2'd2
    } gate_state_e;

endpackage

// File: rtl/cmdreg_gate_ctrl.sv
module cmdreg_gate_ctrl
    import cmdreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_n,
    input  logic        gate_en,
    output logic        load_en,
    output gate_state_e state_q
);

    gate_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and output logic.
    always_comb begin
        load_en = (!sel_n) || (!gate_en);
        unique case (state_q)
            GS_IDLE, GS_LOAD, GS_HOLD: state_d = load_en ? GS_LOAD : GS_HOLD;
            default:                   state_d = GS_IDLE;
        endcase
    end

    // R3
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n) |=> (state_q == GS_LOAD));

    // R2
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && gate_en) |=> (state_q == GS_HOLD));

endmodule

// File: rtl/cmdreg_dual_copy.sv
module cmdreg_dual_copy #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_a,
    output logic [W-1:0] q_b
);

    // Each bit has two separate flops, one per output copy.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_a[i] <= 1'b0;
            end else if (en) begin
                q_a[i] <= d[i];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_b[i] <= 1'b0;
            end else if (en) begin
                q_b[i] <= d[i];
            end
        end
    end

    // R7
    copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_a == q_b));

endmodule

// File: rtl/cs_gated_cmd_reg.sv
module cs_gated_cmd_reg
    import cmdreg_pkg::*;
#(
    parameter int DW = cmdreg_pkg::GATED_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_en,
    input  logic          sel_n,
    input  logic [DW-1:0] data_in,
    input  logic          cke_in,
    input  logic          odt_in,
    output logic [DW-1:0] data_a,
    output logic [DW-1:0] data_b,
    output logic          sel_n_a,
    output logic          sel_n_b,
    output logic          cke_a,
    output logic          cke_b,
    output logic          odt_a,
    output logic          odt_b
);

    localparam int SW = cmdreg_pkg::STROBE_W;

    logic        load_en;
    gate_state_e gate_state;
    logic [SW-1:0] strobe_d;
    logic [SW-1:0] strobe_a;
    logic [SW-1:0] strobe_b;

    cmdreg_gate_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .gate_en (gate_en),
        .load_en (load_en),
        .state_q (gate_state)
    );

    // Gated address/command bank.
    cmdreg_dual_copy #(.W(DW)) u_gated (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (load_en),
        .d     (data_in),
        .q_a   (data_a),
        .q_b   (data_b)
    );

    // Ungated strobes, loaded on every edge.
    assign strobe_d = {sel_n, cke_in, odt_in};

    cmdreg_dual_copy #(.W(SW)) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (1'b1),
        .d     (strobe_d),
        .q_a   (strobe_a),
        .q_b   (strobe_b)
    );

    assign {sel_n_a, cke_a, odt_a} = strobe_a;
    assign {sel_n_b, cke_b, odt_b} = strobe_b;

    // R2
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state == GS_HOLD) |-> $stable(data_a));

    // R3
    sel_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n) |=> (data_a == $past(data_in)));

    // R4
    gate_off_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en) |=> (data_b == $past(data_in)));

    // R5
    strobe_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cke_a == $past(cke_in)) && (odt_b == $past(odt_in)));

    // R6
    sel_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sel_n_b == $past(sel_n)));

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_low_chk: assert ((data_a == '0) && (data_b == '0) &&
                                   (strobe_a == '0) && (strobe_b == '0));
        end
    end

endmodule

// File: tb/test_cs_gated_cmd_reg.sv
`timescale 1ns/1ps
module test_cs_gated_cmd_reg;

    localparam int DW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gate_en = 1'b0;
    logic          sel_n = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          cke_in = 1'b0;
    logic          odt_in = 1'b0;
    logic [DW-1:0] data_a, data_b;
    logic          sel_n_a, sel_n_b, cke_a, cke_b, odt_a, odt_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [DW-1:0] exp_d = '0;
    logic          exp_s = 1'b0, exp_k = 1'b0, exp_o = 1'b0;

    always #2.5 clk = ~clk;

    cs_gated_cmd_reg i_cs_gated_cmd_reg (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .sel_n(sel_n),
        .data_in(data_in), .cke_in(cke_in), .odt_in(odt_in),
        .data_a(data_a), .data_b(data_b), .sel_n_a(sel_n_a), .sel_n_b(sel_n_b),
        .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a), .odt_b(odt_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compare every output against the reference values.
    task automatic check_all(input string req);
        chk({req, " data_a"}, 32'(data_a), 32'(exp_d));
        chk({req, " sel_a"}, 32'(sel_n_a), 32'(exp_s));
        chk({req, " cke_a"}, 32'(cke_a), 32'(exp_k));
        chk({req, " odt_a"}, 32'(odt_a), 32'(exp_o));
        chk("R7 data_b", 32'(data_b), 32'(data_a));
        chk("R7 strobes_b", 32'({sel_n_b, cke_b, odt_b}), 32'({sel_n_a, cke_a, odt_a}));
    endtask

    // Drive one cycle of inputs, update the reference, and step past the edge.
    task automatic cyc(input logic [DW-1:0] d, input logic s, input logic g,
                       input logic k, input logic o);
        data_in = d; sel_n = s; gate_en = g; cke_in = k; odt_in = o;
        if (!s || !g) exp_d = d;
        exp_s = s; exp_k = k; exp_o = o;
        @(posedge clk); #1;
    endtask

    task automatic t_reset_state;
        #1;
        check_all("R1 reset state");
        @(posedge clk); #1;
        check_all("R1 reset held across edge");
        rst_n = 1'b1;
    endtask

    task automatic t_after_release;
        for (int i = 0; i < 3; i++) begin
            cyc('0, 1'b0, 1'b1, 1'b0, 1'b0);
            check_all("R9 stays low");
        end
        cyc(11'h001, 1'b0, 1'b1, 1'b0, 1'b0);
        check_all("R9 first high capture");
    endtask

    task automatic t_sel_load;
        cyc(11'h5A5, 1'b0, 1'b1, 1'b1, 1'b0);
        check_all("R3 load 5A5");
        cyc(11'h2DB, 1'b0, 1'b1, 1'b0, 1'b1);
        check_all("R3 load 2DB");
    endtask

    task automatic t_hold;
        cyc(11'h7FF, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R2 hold data", 32'(data_a), 32'h2DB);
        check_all("R2 hold");
        cyc(11'h000, 1'b1, 1'b1, 1'b0, 1'b0);
        check_all("R2 hold again");
    endtask

    task automatic t_gate_off;
        cyc(11'h3C3, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R4 load deselected", 32'(data_b), 32'h3C3);
        check_all("R4 gate off");
        cyc(11'h1F0, 1'b0, 1'b0, 1'b1, 1'b0);
        check_all("R4 gate off sel");
    endtask

    task automatic t_strobes;
        cyc(11'h0AA, 1'b1, 1'b1, 1'b1, 1'b0);
        check_all("R5 cke while held");
        cyc(11'h055, 1'b1, 1'b1, 1'b0, 1'b1);
        check_all("R5 odt while held");
        cyc(11'h055, 1'b0, 1'b1, 1'b0, 1'b1);
        check_all("R6 sel low");
        cyc(11'h055, 1'b1, 1'b0, 1'b0, 1'b1);
        check_all("R6 sel high");
    endtask

    task automatic t_no_comb;
        cyc(11'h123, 1'b0, 1'b1, 1'b0, 1'b0);
        data_in = 11'h6EE; sel_n = 1'b1; cke_in = 1'b1; odt_in = 1'b1;
        #1;
        check_all("R8 between edges");
        exp_s = 1'b1; exp_k = 1'b1; exp_o = 1'b1;
        @(posedge clk); #1;
        check_all("R8 after edge");
    endtask

    task automatic t_reset_mid;
        cyc(11'h7FF, 1'b0, 1'b1, 1'b1, 1'b1);
        check_all("R1 loaded ones");
        #0.5 rst_n = 1'b0;
        #0.5;
        exp_d = '0; exp_s = 1'b0; exp_k = 1'b0; exp_o = 1'b0;
        check_all("R1 async clear");
        data_in = '0; sel_n = 1'b0; cke_in = 1'b0; odt_in = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        cyc('0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all("R9 low after second release");
    endtask

    initial begin
        t_reset_state();
        t_after_release();
        t_sel_load();
        t_hold();
        t_gate_off();
        t_strobes();
        t_no_comb();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule